// File: doc/BRIEF.md
# Doorbell Mailbox Interrupt Unit

This block links a local processor and a remote processor through three doorbell channels. The channels are low-priority non-secure, high-priority non-secure and secure. Each channel holds two 32-bit status words, one for each direction of travel. A sender raises a doorbell by setting a bit in its outgoing word. The receiver sees that bit in its incoming word and gets an interrupt. The receiver clears the bit once it has handled the event. The sender learns that the event was handled by polling the same bit until it reads back zero.

Both processors reach the unit through their own 32-bit APB slave port. The two ports share the same layout, but the remote port has the directions swapped: the word that is outgoing on one port is incoming on the other. Every bit is set or cleared on its own through a write-one-to-set word and a write-one-to-clear word. Each side has one interrupt line per channel. The line is high while any bit of that side's incoming word is set.

Top module: `dbell_mailbox`

## Requirements
- R1: Channel bases are 0x000 for low priority (index 0), 0x020 for high priority (index 1) and 0x200 for secure (index 2). Each port's incoming register set starts at the channel base and its outgoing set starts at base+0x100. Inside a set, status is at +0x00, set is at +0x08 and clear is at +0x10.
- R2: A write to a set word ORs the written value into the addressed status word.
- R3: A write to a clear word clears every status bit that has a 1 in the written value. All other bits keep their value.
- R4: The local port's outgoing word of a channel is the remote port's incoming word of that channel, and the reverse also holds. A change made from either port is visible from the other port one cycle after the write.
- R5: lclIrq[c] is high exactly while the local incoming word of channel c is nonzero, and rmtIrq[c] does the same for the remote incoming word. Each line stays high until the last set bit is cleared.
- R6: When both ports write the same word in one cycle, a bit that one port sets and the other clears ends up set. Bits touched by only one port follow that port.
- R7: Reads of set and clear words return zero.
- R8: Reads of unmapped offsets return zero and writes to them change nothing. Every access completes with ready high and error low.
- R9: An access to the secure channel (offsets 0x200 to 0x3FF) with protection bit 1 high reads zero and has no effect on write.
- R10: After reset all status words are zero and all interrupt lines are low.
- R11: A write takes effect only in the APB access phase (select and enable both high). A setup phase alone changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rstN | input | 1 | Active-low asynchronous reset |
| lclSel | input | 1 | Local port select |
| lclEnable | input | 1 | Local port enable (access phase) |
| lclWrite | input | 1 | Local port write, 0 for read |
| lclAddr | input | 12 | Local port byte address |
| lclWdata | input | 32 | Local port write data |
| lclProt | input | 3 | Local port protection; bit 1 high marks non-secure |
| lclRdata | output | 32 | Local port read data |
| lclReady | output | 1 | Local port ready, always high |
| lclSlvErr | output | 1 | Local port error, always low |
| rmtSel | input | 1 | Remote port select |
| rmtEnable | input | 1 | Remote port enable (access phase) |
| rmtWrite | input | 1 | Remote port write, 0 for read |
| rmtAddr | input | 12 | Remote port byte address |
| rmtWdata | input | 32 | Remote port write data |
| rmtProt | input | 3 | Remote port protection; bit 1 high marks non-secure |
| rmtRdata | output | 32 | Remote port read data |
| rmtReady | output | 1 | Remote port ready, always high |
| rmtSlvErr | output | 1 | Remote port error, always low |
| lclIrq | output | 3 | Local interrupts, one per channel |
| rmtIrq | output | 3 | Remote interrupts, one per channel |

## Verification
A write commits on the rising edge that ends its access phase. The new status word, and the interrupt lines of both sides, can be seen from the falling edge that follows. Read data is combinational from the current status while select is high, so it is valid during the access phase with no wait state. The bench drives every input on falling edges and samples read data one time unit after the falling edge of the access phase. It checks interrupt lines at the falling edge after a write's commit edge, so every compare lands in the cycle where the result is due.

// File: rtl/dbmb_pkg.sv
package dbmb_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 12;
  localparam int NUM_CH    = 3;
  localparam int SEC_CH    = NUM_CH - 1;
  localparam int CH_W      = $clog2(NUM_CH);
  localparam int IDX_W     = CH_W + 1;
  localparam int NUM_WORDS = 2 * NUM_CH;
  localparam int TX_BIT    = 8;
  localparam int CH_STRIDE = 32;
  localparam logic [ADDR_W-1:0] SEC_BASE = 12'h200;
  localparam logic [4:0] OFS_STAT = 5'h00;
  localparam logic [4:0] OFS_SET  = 5'h08;
  localparam logic [4:0] OFS_CLR  = 5'h10;

  typedef struct packed {
    logic              rdStat;
    logic              wrSet;
    logic              wrClr;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data;
  } strobe_t;

  function automatic logic [ADDR_W-1:0] chanBase(input int c);
    if (c == SEC_CH) return SEC_BASE;
    return ADDR_W'(c * CH_STRIDE);
  endfunction
endpackage

// File: rtl/dbmb_decode.sv
module dbmb_decode
  import dbmb_pkg::*;
#(
  parameter bit IS_REMOTE = 1'b0
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [2:0]        pprot,
  output strobe_t           stb
);
  logic            hit;
  logic            blocked;
  logic [CH_W-1:0] ch;
  logic            dir;
  logic            live;
  logic [ADDR_W-1:0] base;

  always_comb begin
    hit  = 1'b0;
    ch   = '0;
    base = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      base = chanBase(c);
      if (paddr[ADDR_W-1:TX_BIT+1] == base[ADDR_W-1:TX_BIT+1] &&
          paddr[TX_BIT-1:5] == base[TX_BIT-1:5]) begin
        hit = 1'b1;
        ch  = CH_W'(c);
      end
    end
    blocked = hit && (ch == CH_W'(SEC_CH)) && pprot[1];
    dir     = paddr[TX_BIT] ^ IS_REMOTE;
    live    = psel && hit && !blocked;

    stb.idx    = {ch, dir};
    stb.data   = pwdata;
    stb.rdStat = live && !pwrite && (paddr[4:0] == OFS_STAT);
    stb.wrSet  = live && penable && pwrite && (paddr[4:0] == OFS_SET);
    stb.wrClr  = live && penable && pwrite && (paddr[4:0] == OFS_CLR);
  end
endmodule

// File: rtl/dbmb_words.sv
module dbmb_words
  import dbmb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           lclStb,
  input  strobe_t           rmtStb,
  output logic [DATA_W-1:0] lclRdata,
  output logic [DATA_W-1:0] rmtRdata,
  output logic [NUM_CH-1:0] lclIrq,
  output logic [NUM_CH-1:0] rmtIrq
);
  logic [NUM_WORDS-1:0][DATA_W-1:0] word;
  logic [NUM_WORDS-1:0][DATA_W-1:0] nxtWord;

  always_comb begin
    for (int w = 0; w < NUM_WORDS; w++) begin
      logic [DATA_W-1:0] setMask;
      logic [DATA_W-1:0] clrMask;
      setMask = '0;
      clrMask = '0;
      if (lclStb.wrSet && lclStb.idx == IDX_W'(w)) setMask |= lclStb.data;
      if (rmtStb.wrSet && rmtStb.idx == IDX_W'(w)) setMask |= rmtStb.data;
      if (lclStb.wrClr && lclStb.idx == IDX_W'(w)) clrMask |= lclStb.data;
      if (rmtStb.wrClr && rmtStb.idx == IDX_W'(w)) clrMask |= rmtStb.data;
      nxtWord[w] = (word[w] & ~clrMask) | setMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) word <= '0;
    else       word <= nxtWord;
  end

  always_comb begin
    lclRdata = '0;
    rmtRdata = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (lclStb.rdStat && lclStb.idx == IDX_W'(w)) lclRdata = word[w];
      if (rmtStb.rdStat && rmtStb.idx == IDX_W'(w)) rmtRdata = word[w];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : gIrq
    assign lclIrq[c] = |word[2*c];
    assign rmtIrq[c] = |word[2*c+1];
  end
endmodule

// File: rtl/dbell_mailbox.sv
module dbell_mailbox
  import dbmb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              lclSel,
  input  logic              lclEnable,
  input  logic              lclWrite,
  input  logic [ADDR_W-1:0] lclAddr,
  input  logic [DATA_W-1:0] lclWdata,
  input  logic [2:0]        lclProt,
  output logic [DATA_W-1:0] lclRdata,
  output logic              lclReady,
  output logic              lclSlvErr,
  input  logic              rmtSel,
  input  logic              rmtEnable,
  input  logic              rmtWrite,
  input  logic [ADDR_W-1:0] rmtAddr,
  input  logic [DATA_W-1:0] rmtWdata,
  input  logic [2:0]        rmtProt,
  output logic [DATA_W-1:0] rmtRdata,
  output logic              rmtReady,
  output logic              rmtSlvErr,
  output logic [NUM_CH-1:0] lclIrq,
  output logic [NUM_CH-1:0] rmtIrq
);
  strobe_t lclStb;
  strobe_t rmtStb;

  dbmb_decode #(.IS_REMOTE(1'b0)) lclDec_i (
    .psel(lclSel), .penable(lclEnable), .pwrite(lclWrite),
    .paddr(lclAddr), .pwdata(lclWdata), .pprot(lclProt), .stb(lclStb)
  );

  dbmb_decode #(.IS_REMOTE(1'b1)) rmtDec_i (
    .psel(rmtSel), .penable(rmtEnable), .pwrite(rmtWrite),
    .paddr(rmtAddr), .pwdata(rmtWdata), .pprot(rmtProt), .stb(rmtStb)
  );

  dbmb_words words_i (
    .clk(clk), .rstN(rstN), .lclStb(lclStb), .rmtStb(rmtStb),
    .lclRdata(lclRdata), .rmtRdata(rmtRdata),
    .lclIrq(lclIrq), .rmtIrq(rmtIrq)
  );

  assign lclReady  = 1'b1;
  assign rmtReady  = 1'b1;
  assign lclSlvErr = 1'b0;
  assign rmtSlvErr = 1'b0;
endmodule

// File: rtl/dbell_mailbox_chk.sv
module dbell_mailbox_chk
  import dbmb_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              lclSel,
  input logic              lclEnable,
  input logic              lclWrite,
  input logic [ADDR_W-1:0] lclAddr,
  input logic [DATA_W-1:0] lclWdata,
  input logic [2:0]        lclProt,
  input logic [DATA_W-1:0] lclRdata,
  input logic              rmtSel,
  input logic              rmtEnable,
  input logic              rmtWrite,
  input logic [ADDR_W-1:0] rmtAddr,
  input logic [DATA_W-1:0] rmtWdata,
  input logic [NUM_CH-1:0] lclIrq,
  input logic [NUM_CH-1:0] rmtIrq
);
  logic lclWr;
  logic rmtWr;
  assign lclWr = lclSel && lclEnable && lclWrite;
  assign rmtWr = rmtSel && rmtEnable && rmtWrite;

  for (genvar c = 0; c < NUM_CH; c++) begin : gHold
    // R5: with no write on either port an interrupt line keeps its level
    a_r5_irq_hold: assert property (@(posedge clk) disable iff (!rstN)
      (lclIrq[c] && !lclWr && !rmtWr) |=> lclIrq[c]);
    a_r5_irq_quiet: assert property (@(posedge clk) disable iff (!rstN)
      (!rmtIrq[c] && !lclWr && !rmtWr) |=> !rmtIrq[c]);
  end

  a_r2_set_raises_remote: assert property (@(posedge clk) disable iff (!rstN)
    (lclWr && lclAddr == 12'h108 && lclWdata != 0) |=> rmtIrq[0]);

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (rmtWr && rmtAddr == 12'h108 && rmtWdata != 0 &&
     lclWr && lclAddr == 12'h010) |=> lclIrq[0]);

  a_r7_set_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (lclSel && !lclWrite && lclAddr[4:0] == 5'h08) |-> lclRdata == '0);

  a_r9_secure_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (lclSel && !lclWrite && lclProt[1] && lclAddr[11:9] == 3'b001)
      |-> lclRdata == '0);
endmodule

bind dbell_mailbox dbell_mailbox_chk chk_i (
  .clk(clk), .rstN(rstN),
  .lclSel(lclSel), .lclEnable(lclEnable), .lclWrite(lclWrite),
  .lclAddr(lclAddr), .lclWdata(lclWdata), .lclProt(lclProt),
  .lclRdata(lclRdata),
  .rmtSel(rmtSel), .rmtEnable(rmtEnable), .rmtWrite(rmtWrite),
  .rmtAddr(rmtAddr), .rmtWdata(rmtWdata),
  .lclIrq(lclIrq), .rmtIrq(rmtIrq)
);

// File: tb/dbell_mailbox_tb_top.sv
module dbell_mailbox_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lclSel = 0, lclEnable = 0, lclWrite = 0;
  logic [11:0] lclAddr = '0;
  logic [31:0] lclWdata = '0;
  logic [2:0]  lclProt = '0;
  logic [31:0] lclRdata;
  logic        lclReady, lclSlvErr;
  logic        rmtSel = 0, rmtEnable = 0, rmtWrite = 0;
  logic [11:0] rmtAddr = '0;
  logic [31:0] rmtWdata = '0;
  logic [2:0]  rmtProt = '0;
  logic [31:0] rmtRdata;
  logic        rmtReady, rmtSlvErr;
  logic [2:0]  lclIrq, rmtIrq;

  int nChecks = 0;
  int nErrs   = 0;
  bit done    = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t       sbq[$];
  event        rdDone;
  logic [31:0] gotData;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbell_mailbox dut_i (.*);

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nErrs++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // monitor: pops the expected item as each read result appears
  initial begin
    forever begin
      @(rdDone);
      if (sbq.size() == 0) begin
        check("scoreboard underflow", 32'd1, 32'd0);
      end else begin
        item_t it;
        it = sbq.pop_front();
        check(it.tag, gotData, it.exp);
      end
    end
  end

  task automatic apbWr(input bit rmt, input logic [11:0] a, input logic [31:0] d,
                       input logic [2:0] prot = 3'b000);
    @(negedge clk);
    if (rmt) begin rmtSel = 1; rmtWrite = 1; rmtAddr = a; rmtWdata = d; rmtProt = prot; end
    else     begin lclSel = 1; lclWrite = 1; lclAddr = a; lclWdata = d; lclProt = prot; end
    @(negedge clk);
    if (rmt) rmtEnable = 1; else lclEnable = 1;
    @(negedge clk);
    rmtSel = 0; rmtEnable = 0; rmtWrite = 0; rmtProt = 0;
    lclSel = 0; lclEnable = 0; lclWrite = 0; lclProt = 0;
  endtask

  task automatic dualWr(input logic [11:0] la, input logic [31:0] ld,
                        input logic [11:0] ra, input logic [31:0] rd);
    @(negedge clk);
    lclSel = 1; lclWrite = 1; lclAddr = la; lclWdata = ld;
    rmtSel = 1; rmtWrite = 1; rmtAddr = ra; rmtWdata = rd;
    @(negedge clk);
    lclEnable = 1; rmtEnable = 1;
    @(negedge clk);
    lclSel = 0; lclEnable = 0; lclWrite = 0;
    rmtSel = 0; rmtEnable = 0; rmtWrite = 0;
  endtask

  // driver: pushes expectation, runs the read, publishes the result
  task automatic expRd(input bit rmt, input logic [11:0] a, input logic [31:0] exp,
                       input string tag, input logic [2:0] prot = 3'b000);
    item_t it;
    it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    if (rmt) begin rmtSel = 1; rmtWrite = 0; rmtAddr = a; rmtProt = prot; end
    else     begin lclSel = 1; lclWrite = 0; lclAddr = a; lclProt = prot; end
    @(negedge clk);
    if (rmt) rmtEnable = 1; else lclEnable = 1;
    #1;
    gotData = rmt ? rmtRdata : lclRdata;
    check({tag, " ready/err"}, rmt ? {30'd0, rmtReady, rmtSlvErr} : {30'd0, lclReady, lclSlvErr},
          32'd2);
    ->rdDone;
    #1;
    @(negedge clk);
    rmtSel = 0; rmtEnable = 0; rmtProt = 0;
    lclSel = 0; lclEnable = 0; lclProt = 0;
  endtask

  task automatic chkIrq(input logic [2:0] expL, input logic [2:0] expR, input string tag);
    check({tag, " lclIrq"}, {29'd0, lclIrq}, {29'd0, expL});
    check({tag, " rmtIrq"}, {29'd0, rmtIrq}, {29'd0, expR});
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      if (sbq.size() != 0) check("scoreboard leftover", sbq.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    nChecks++; nErrs++;
    $display("FAIL watchdog: got timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R10: reset state
    chkIrq(3'b000, 3'b000, "R10 reset");
    for (int i = 0; i < 3; i++) begin
      logic [11:0] b;
      b = (i == 2) ? 12'h200 : 12'(i * 32);
      expRd(0, b, 0, "R10 rx word zero");
      expRd(0, b + 12'h100, 0, "R10 tx word zero");
    end

    // R2 R4 R5: local raises doorbells on low-priority channel
    apbWr(0, 12'h108, 32'h0000_0011);
    chkIrq(3'b000, 3'b001, "R5 remote irq after set");
    expRd(0, 12'h100, 32'h11, "R2 local tx status");
    expRd(1, 12'h000, 32'h11, "R4 remote rx sees local tx");
    apbWr(0, 12'h108, 32'h0000_0100);
    expRd(0, 12'h100, 32'h111, "R2 set ORs in");

    // R7: set and clear words read zero
    expRd(0, 12'h108, 0, "R7 set word reads zero");
    expRd(1, 12'h010, 0, "R7 clear word reads zero");

    // R3 R5: remote clears one bit, irq stays until last bit gone
    apbWr(1, 12'h010, 32'h0000_0001);
    expRd(0, 12'h100, 32'h110, "R3 clear one bit");
    chkIrq(3'b000, 3'b001, "R5 irq held with bits left");
    apbWr(1, 12'h010, 32'h0000_0110);
    chkIrq(3'b000, 3'b000, "R5 irq drops after last clear");

    // R1 R4: remote raises high-priority doorbell toward local
    apbWr(1, 12'h128, 32'h8000_0000);
    chkIrq(3'b010, 3'b000, "R1 high-priority local irq");
    expRd(0, 12'h020, 32'h8000_0000, "R1 local rx high-priority");
    apbWr(0, 12'h030, 32'h8000_0000);
    chkIrq(3'b000, 3'b000, "R3 local clears high-priority");

    // R11: setup phase only does nothing
    @(negedge clk);
    lclSel = 1; lclWrite = 1; lclAddr = 12'h108; lclWdata = 32'hFFFF_FFFF;
    @(negedge clk);
    lclSel = 0; lclWrite = 0;
    chkIrq(3'b000, 3'b000, "R11 setup phase ignored");

    // R9 R1: secure channel
    apbWr(0, 12'h308, 32'h0000_0005);
    chkIrq(3'b000, 3'b100, "R1 secure remote irq");
    expRd(1, 12'h200, 32'h5, "R1 secure remote rx");
    expRd(1, 12'h200, 0, "R9 non-secure read blocked", 3'b010);
    apbWr(1, 12'h210, 32'h0000_0005, 3'b010);
    expRd(1, 12'h200, 32'h5, "R9 non-secure clear ignored");
    apbWr(1, 12'h210, 32'h0000_0005);
    chkIrq(3'b000, 3'b000, "R9 secure clear works");

    // R8: unmapped offsets
    apbWr(0, 12'h104, 32'hFFFF_FFFF);
    apbWr(0, 12'h0C8, 32'hFFFF_FFFF);
    apbWr(1, 12'h040, 32'hFFFF_FFFF);
    chkIrq(3'b000, 3'b000, "R8 unmapped writes ignored");
    expRd(0, 12'h0C0, 0, "R8 unmapped read zero");
    expRd(0, 12'h100, 0, "R8 status untouched");

    // R6: simultaneous set and clear on one word
    apbWr(1, 12'h108, 32'h0000_000F);
    dualWr(12'h010, 32'h0000_003C, 12'h108, 32'h0000_0030);
    expRd(0, 12'h000, 32'h33, "R6 set wins over clear");
    chkIrq(3'b001, 3'b000, "R6 irq after merge");

    repeat (2) @(negedge clk);
    finish();
  end
endmodule